// File: doc/BRIEF.md
# Two-Wire Control Port Register Slave

This block is a write-only slave on a two-wire serial configuration bus. It samples the clock and data lines into the system clock domain and recognises the bus START and STOP conditions. It checks the 7-bit device address and acknowledges the address byte and each data byte. Two data bytes make up one 16-bit control word. The top seven bits of that word select a register, and the low nine bits are the value written into it.

Ten 9-bit configuration registers are presented in parallel on one flat output bus. The system reads them directly. A write to register index 0x0F returns every register to its default value. Registers 0 and 1 form a linked pair: when bit 8 of the written value is set, the same value is written into both registers of the pair.

The protocol engine is a seven-state machine:

- `ST_IDLE` ignores the bus until a START arrives.
- `ST_ADDR` shifts in the address byte.
- `ST_ACK_ADDR` holds the acknowledge for the address byte.
- `ST_DATA_HI` and `ST_DATA_LO` shift in the two data bytes.
- `ST_ACK_HI` and `ST_ACK_LO` hold the acknowledge for each data byte.

Its transitions are:

- START, from any state, goes to `ST_ADDR`.
- STOP, from any state, goes to `ST_IDLE`.
- In the byte states, the falling SCL edge after the eighth bit moves to the matching acknowledge state. From `ST_ADDR`, an address mismatch or a read request goes to `ST_IDLE` instead.
- The falling SCL edge that ends the ninth clock moves each acknowledge state on to the next byte state.
- `ST_ACK_LO` commits the write on that edge and returns to `ST_IDLE`.

Top module: `ctl_port_regs`

## Requirements
- R1: After reset, registers 0 and 1 hold 9'h097, registers 2 to 9 hold 9'h000, and the data line is not driven.
- R2: A START is a falling SDA edge while SCL is high. The first byte after it carries a 7-bit device address MSB first and then an R/W bit, where 0 means write. A matching write address is acknowledged by pulling SDA low during the ninth clock.
- R3: If the device address does not match, neither the address byte nor any later byte is acknowledged, and no register changes until the next START.
- R4: An address byte with R/W = 1 is treated like a mismatch: no acknowledge and no register change.
- R5: Each of the two data bytes after an acknowledged address is acknowledged on its own ninth clock.
- R6: The first data byte carries word bits 15..8 and the second carries bits 7..0, both MSB first. Bits [15:9] form the register index and bits [8:0] form the value. Register k appears on `reg_bus[9k+8:9k]`. The value is committed only at the falling SCL edge that ends the second acknowledge.
- R7: Writes to indexes 0x0A–0x0E and 0x10–0x7F are acknowledged and change no register.
- R8: Any write to index 0x0F restores all registers to their R1 defaults, whatever value is written.
- R9: A STOP (a rising SDA edge while SCL is high) that arrives before the second data acknowledge completes discards the partial word.
- R10: A repeated START in the middle of a word aborts that word, and the new frame that follows is handled normally.
- R11: A write to register 0 or 1 with value bit 8 = 1 stores the same 9-bit value in both registers. With bit 8 = 0, only the addressed register changes.
- R12: The acknowledge drive changes only while SCL is low, and it is released within a few system clocks of the falling SCL edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line as seen on the wire, asynchronous |
| sda_drive_low | output | 1 | When 1, the open-drain data pad pulls SDA low (acknowledge) |
| reg_bus | output | 90 | All ten registers, register k at bits [9k+8:9k] |

## Verification
A wrong state in the protocol machine shows up at `sda_drive_low` within the same byte. The acknowledge is either missing or present when it should not be, and this can be seen on the ninth clock of the byte being received. A bit counter or shift register that has slipped does not change the acknowledge pattern. It shows up instead on `reg_bus` at the end of the frame, as a value in the wrong register or with shifted bits. The bench therefore compares the whole register bus against a model after every frame. A commit that happens too early shows up when a frame is cut short by STOP or by a repeated START: a register changes although the word was never completed.

// File: rtl/cp_pkg.sv
package cp_pkg;

    localparam int REG_W     = 9;
    localparam int IDX_W     = 7;
    localparam int DEV_W     = 7;
    localparam int N_REGS    = 10;
    localparam int RST_IDX   = 15;
    localparam int LINK_A    = 0;
    localparam int LINK_B    = 1;
    localparam int LINK_BIT  = 8;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam int WORD_W    = IDX_W + REG_W;
    localparam int BUS_W     = N_REGS * REG_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_DATA_HI,
        ST_ACK_HI,
        ST_DATA_LO,
        ST_ACK_LO
    } cp_state_e;

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        if (idx == LINK_A || idx == LINK_B) return 9'h097;
        return '0;
    endfunction

    function automatic logic [BUS_W-1:0] default_bus();
        logic [BUS_W-1:0] b;
        for (int k = 0; k < N_REGS; k++) b[k*REG_W +: REG_W] = reg_default(k);
        return b;
    endfunction

endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cp_fsm.sv
module cp_fsm
    import cp_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 7'h1A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    output logic             sda_drive_low,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_val
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    cp_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        addr_sh;
    logic [WORD_W-1:0] word_sh;
    logic              addr_ok;

    assign addr_ok = (addr_sh[7:1] == DEV_ADDR) && !addr_sh[0];

    // State register with its shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            addr_sh <= '0;
            word_sh <= '0;
        end else if (start_ev) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (stop_ev) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && cnt != FULL) begin
                        addr_sh <= {addr_sh[6:0], sda_s};
                        cnt     <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        state <= addr_ok ? ST_ACK_ADDR : ST_IDLE;
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        state <= ST_DATA_HI;
                        cnt   <= '0;
                    end
                end
                ST_DATA_HI: begin
                    if (scl_rise && cnt != FULL) begin
                        word_sh <= {word_sh[WORD_W-2:0], sda_s};
                        cnt     <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        state <= ST_ACK_HI;
                    end
                end
                ST_ACK_HI: begin
                    if (scl_fall) begin
                        state <= ST_DATA_LO;
                        cnt   <= '0;
                    end
                end
                ST_DATA_LO: begin
                    if (scl_rise && cnt != FULL) begin
                        word_sh <= {word_sh[WORD_W-2:0], sda_s};
                        cnt     <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        state <= ST_ACK_LO;
                    end
                end
                ST_ACK_LO: begin
                    if (scl_fall) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        sda_drive_low = 1'b0;
        wr_en         = 1'b0;
        unique case (state)
            ST_ACK_ADDR, ST_ACK_HI: sda_drive_low = 1'b1;
            ST_ACK_LO: begin
                sda_drive_low = 1'b1;
                wr_en         = scl_fall;
            end
            default: ;
        endcase
        wr_idx = word_sh[WORD_W-1 -: IDX_W];
        wr_val = word_sh[REG_W-1:0];
    end

endmodule

// File: rtl/cp_regfile.sv
module cp_regfile
    import cp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_val,
    output logic [BUS_W-1:0] reg_bus
);

    logic wipe;
    assign wipe = wr_en && (wr_idx == IDX_W'(RST_IDX));

    for (genvar k = 0; k < N_REGS; k++) begin : g_reg
        localparam int               PARTNER = (k == LINK_A) ? LINK_B :
                                               (k == LINK_B) ? LINK_A : k;
        localparam bit               LINKED  = (PARTNER != k);
        localparam logic [IDX_W-1:0] MY_IDX  = IDX_W'(k);
        localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(PARTNER);
        localparam logic [REG_W-1:0] DEF     = reg_default(k);

        logic [REG_W-1:0] val_q;
        logic             hit;

        assign hit = wr_en && ((wr_idx == MY_IDX) ||
                     (LINKED && wr_idx == PAR_IDX && wr_val[LINK_BIT]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   val_q <= DEF;
            else if (wipe) val_q <= DEF;
            else if (hit)  val_q <= wr_val;
        end

        assign reg_bus[k*REG_W +: REG_W] = val_q;
    end

endmodule

// File: rtl/ctl_port_regs.sv
module ctl_port_regs
    import cp_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR    = 7'h1A,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_drive_low,
    output logic [BUS_W-1:0] reg_bus
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [REG_W-1:0] wr_val;

    cp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    cp_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_s         (sda_s),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_ev      (start_ev),
        .stop_ev       (stop_ev),
        .sda_drive_low (sda_drive_low),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_val        (wr_val)
    );

    cp_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val),
        .reg_bus (reg_bus)
    );

endmodule

// File: rtl/ctl_port_regs_chk.sv
module cp_checker
    import cp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [REG_W-1:0] wr_val,
    input logic             sda_drive_low,
    input logic [BUS_W-1:0] reg_bus
);

    // R6 / R9: registers move only in the cycle after a committed write
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_bus));

    // R6 / R12: the acknowledge is released right after the commit
    a_r6_release_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !sda_drive_low);

    // R8: a write to the reset index restores every default
    a_r8_wipe_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(RST_IDX)) |=> (reg_bus == default_bus()));

    // R11: linked pair receives the same value when bit 8 is set
    a_r11_link_from_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(LINK_A) && wr_val[LINK_BIT])
        |=> (reg_bus[LINK_B*REG_W +: REG_W] == $past(wr_val)));

    a_r11_link_from_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(LINK_B) && wr_val[LINK_BIT])
        |=> (reg_bus[LINK_A*REG_W +: REG_W] == $past(wr_val)));

    // R12: acknowledge drive turns on and off only with SCL low
    a_r12_ack_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_s);

    a_r12_ack_off_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low) |-> !scl_s);

endmodule

bind ctl_port_regs cp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_val        (wr_val),
    .sda_drive_low (sda_drive_low),
    .reg_bus       (reg_bus)
);

// File: tb/ctl_port_regs_bench.sv
module ctl_port_regs_bench;

    localparam logic [6:0] DEV = 7'h1A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_drive_low;
    logic [89:0] reg_bus;
    logic        sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [8:0] model [10];

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_drive_low;

    ctl_port_regs #(.DEV_ADDR(DEV)) u_ctl_port_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low),
        .reg_bus       (reg_bus)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [89:0] model_bus();
        logic [89:0] b;
        for (int k = 0; k < 10; k++) b[k*9 +: 9] = model[k];
        return b;
    endfunction

    task automatic model_defaults();
        for (int k = 0; k < 10; k++) model[k] = (k < 2) ? 9'h097 : 9'h000;
    endtask

    task automatic model_write(input int idx, input logic [8:0] v);
        if (idx == 15) model_defaults();
        else if (idx < 10) begin
            model[idx] = v;
            if (idx == 0 && v[8]) model[1] = v;
            if (idx == 1 && v[8]) model[0] = v;
        end
    endtask

    task automatic send_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic send_rstart();
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic send_stop();
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(4);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic get_ack(output logic a);
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(4);
        a = ~sda_bus;
        tick(4);
        m_scl = 1'b0; tick(6);
        chk("R12 ack released after ninth clock", {95'd0, sda_drive_low}, 96'd0);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_ack(a);
    endtask

    task automatic write_frame(input logic [6:0] dev, input logic rw, input logic [6:0] idx,
                               input logic [8:0] v, output logic [2:0] acks);
        logic a0, a1, a2;
        send_start();
        send_byte({dev, rw}, a0);
        send_byte({idx, v[8]}, a1);
        send_byte(v[7:0], a2);
        send_stop();
        tick(4);
        acks = {a0, a1, a2};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic a0, a1;
        model_defaults();
        tick(5);
        // R1: reset state
        chk("R1 defaults", {6'd0, reg_bus}, {6'd0, model_bus()});
        chk("R1 sda idle", {95'd0, sda_drive_low}, 96'd0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 defaults after release", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R2 R5 R6 R7 R8: sweep every index 0..15
        for (int idx = 0; idx < 16; idx++) begin
            logic [8:0] v;
            v = 9'((idx * 73 + 11) % 512);
            if (idx < 2) v[8] = 1'b0;
            write_frame(DEV, 1'b0, 7'(idx), v, acks);
            model_write(idx, v);
            chk("R2 R5 acks on sweep", {93'd0, acks}, 96'd7);
            chk("R6 R7 R8 bus after sweep write", {6'd0, reg_bus}, {6'd0, model_bus()});
        end

        // R6: volume code sweep into register 0 with mute toggling
        for (int c = 0; c < 32; c++) begin
            logic [8:0] v;
            v = {1'b0, c[0], 2'b01, c[4:0]};
            write_frame(DEV, 1'b0, 7'd0, v, acks);
            model_write(0, v);
            chk("R6 volume sweep", {6'd0, reg_bus}, {6'd0, model_bus()});
        end

        // R7: high unlisted index
        write_frame(DEV, 1'b0, 7'h55, 9'h1AB, acks);
        chk("R7 unlisted ack", {93'd0, acks}, 96'd7);
        chk("R7 unlisted no effect", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R3: wrong device address
        write_frame(7'h1B, 1'b0, 7'd4, 9'h0FF, acks);
        chk("R3 mismatch no ack", {93'd0, acks}, 96'd0);
        chk("R3 mismatch no write", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R4: read request
        write_frame(DEV, 1'b1, 7'd5, 9'h0AA, acks);
        chk("R4 read no ack", {93'd0, acks}, 96'd0);
        chk("R4 read no write", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R11: linked pair
        write_frame(DEV, 1'b0, 7'd0, 9'h15A, acks);
        model_write(0, 9'h15A);
        chk("R11 link from reg0", {6'd0, reg_bus}, {6'd0, model_bus()});
        write_frame(DEV, 1'b0, 7'd1, 9'h10F, acks);
        model_write(1, 9'h10F);
        chk("R11 link from reg1", {6'd0, reg_bus}, {6'd0, model_bus()});
        write_frame(DEV, 1'b0, 7'd0, 9'h033, acks);
        model_write(0, 9'h033);
        chk("R11 no link when bit8 clear", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R9: STOP after first data byte
        send_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte({7'd6, 1'b1}, a1);
        send_stop();
        tick(4);
        chk("R9 acks before stop", {94'd0, a0, a1}, 96'd3);
        chk("R9 stop discards", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R9: STOP in the middle of the second data byte
        send_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte({7'd7, 1'b0}, a1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        send_stop();
        tick(4);
        chk("R9 mid-byte stop discards", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R10: repeated START aborts the partial word
        send_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte({7'd2, 1'b1}, a1);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        send_rstart();
        send_byte({DEV, 1'b0}, a0);
        send_byte({7'd3, 1'b1}, a1);
        send_byte(8'h5C, a0);
        send_stop();
        tick(4);
        model_write(3, 9'h15C);
        chk("R10 repeated start", {6'd0, reg_bus}, {6'd0, model_bus()});

        // R8: reset register restores defaults
        write_frame(DEV, 1'b0, 7'h0F, 9'h000, acks);
        model_write(15, 9'h000);
        chk("R8 reset register", {6'd0, reg_bus}, {6'd0, model_bus()});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule